// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block supplies the address for a synchronous burst memory. When either of two start strobes is asserted, it registers the external address. Each later advance request then moves only the two least significant bits through a four-beat sequence. The upper bits keep the value they were loaded with. A mode input selects the sequence. In linear order the low bits count up and wrap modulo four. In interleaved order the beat index is XORed into the starting low bits.

Bursting is optional. Asserting a strobe every cycle loads a new external address every cycle, and this costs no extra cycles. When nothing is requested, the address holds. The mode input is meant to be tied off. A design that leaves it unconnected should tie it to 1, which selects interleaved order.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, addr_q is all zeros.
- R2: If strb_a or strb_b is high at a rising edge, addr_q equals ext_addr after that edge.
- R3: If a strobe and adv are high at the same edge, the load wins and addr_q equals ext_addr.
- R4: If no strobe and no adv are high at an edge, addr_q is unchanged.
- R5: An advance never changes addr_q[AW-1:2].
- R6: With order_ilv=0, an advance sets addr_q[1:0] to (start+beat+1) mod 4, where start is the loaded low bits and beat is the number of advances since the load. Start 1 gives 1,2,3,0.
- R7: With order_ilv=1, an advance sets addr_q[1:0] to start XOR (beat+1) mod 4. Start 1 gives 1,0,3,2, and start 2 gives 2,3,0,1.
- R8: After four advances the sequence wraps to the start value in both orders.
- R9: The value 1 on order_ilv selects interleaved order, which is the order used when the mode input is left unconnected and tied to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | AW | External address |
| strb_a | input | 1 | Burst start strobe A |
| strb_b | input | 1 | Burst start strobe B |
| adv | input | 1 | Advance to the next beat |
| order_ilv | input | 1 | 1 selects interleaved order, 0 selects linear order |
| addr_q | output | AW | Current internal address |

## Verification
The bench builds the block with AW=8. This makes the upper six bits easy to check against a known pattern, so any carry out of the low two bits during an advance would show up. Every one of the four start offsets is run through a full wrap in both orders. Back-to-back loads and strobe-with-advance collisions are also driven at that width.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          strb_a,
  input  logic          strb_b,
  input  logic          adv,
  input  logic          order_ilv,
  output logic [AW-1:0] addr_q
);
  localparam int HW = AW - 2;

  logic [HW-1:0] hi_q;
  logic [1:0]    start_q, beat_q, beat_nx, lo_nx;
  logic          load;

  assign load    = strb_a | strb_b;
  assign beat_nx = beat_q + 2'd1;
  assign lo_nx   = order_ilv ? (start_q ^ beat_nx) : (start_q + beat_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      beat_q  <= '0;
      addr_q  <= '0;
    end else if (load) begin
      hi_q    <= ext_addr[AW-1:2];
      start_q <= ext_addr[1:0];
      beat_q  <= '0;
      addr_q  <= ext_addr;
    end else if (adv) begin
      beat_q  <= beat_nx;
      addr_q  <= {hi_q, lo_nx};
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_a || strb_b) |=> addr_q == $past(ext_addr));
  assert_collision_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb_a || strb_b) && adv) |=> addr_q == $past(ext_addr));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_a && !strb_b && !adv) |=> $stable(addr_q));
  assert_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_a && !strb_b && adv) |=> addr_q[AW-1:2] == $past(addr_q[AW-1:2]));
  assert_linstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_a && !strb_b && adv && !order_ilv && beat_q == 2'd0)
      |=> addr_q[1:0] == $past(addr_q[1:0]) + 2'd1);
  assert_ilvstep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_a && !strb_b && adv && order_ilv && beat_q == 2'd0)
      |=> addr_q[1:0] == ($past(addr_q[1:0]) ^ 2'd1));
endmodule

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0, strb_a = 0, strb_b = 0, adv = 0, order_ilv = 1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] addr_q;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .strb_a(strb_a),
    .strb_b(strb_b), .adv(adv), .order_ilv(order_ilv), .addr_q(addr_q));

  task automatic chk(input string req, input logic [AW-1:0] exp);
    total++;
    if (addr_q !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, addr_q, exp);
    end
  endtask

  task automatic step(input logic a, input logic b, input logic v, input logic [AW-1:0] ad);
    strb_a = a; strb_b = b; adv = v; ext_addr = ad;
    @(posedge clk); #2;
    strb_a = 0; strb_b = 0; adv = 0;
  endtask

  task automatic t_reset;
    ext_addr = 8'hFF; strb_a = 1; adv = 1;
    repeat (2) @(posedge clk);
    #2 chk("R1", '0);
    strb_a = 0; adv = 0; rst_n = 1;
  endtask

  task automatic t_seq(input logic ilv, input logic [1:0] st, input logic useb);
    logic [AW-1:0] base;
    base = {6'b101101, st};
    order_ilv = ilv;
    step(!useb, useb, 0, base);
    chk("R2", base);
    for (int n = 1; n <= 4; n++) begin
      logic [1:0] e;
      e = ilv ? (st ^ 2'(n)) : (st + 2'(n));
      step(0, 0, 1, 8'h00);
      if (ilv) chk("R7", {6'b101101, e}); else chk("R6", {6'b101101, e});
    end
    chk("R8", base);
    chk("R5", {6'b101101, addr_q[1:0]});
  endtask

  task automatic t_hold_collide;
    order_ilv = 0;
    step(1, 0, 0, 8'h42);
    step(0, 0, 1, 8'h00);
    step(0, 0, 0, 8'h99);
    chk("R4", 8'h43);
    step(0, 1, 1, 8'hC6);
    chk("R3", 8'hC6);
    step(1, 0, 0, 8'h11);
    step(0, 1, 0, 8'h22);
    chk("R2", 8'h22);
  endtask

  task automatic t_default;
    order_ilv = 1;
    step(1, 0, 0, 8'h01);
    step(0, 0, 1, 0);
    chk("R9", 8'h00);
    step(0, 0, 1, 0);
    chk("R9", 8'h03);
  endtask

  initial begin
    #1;
    t_reset;
    for (int s = 0; s < 4; s++) begin
      t_seq(0, 2'(s), s[0]);
      t_seq(1, 2'(s), !s[0]);
    end
    t_hold_collide;
    t_default;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); total++; bad++; $display("FAIL watchdog: actual=hung expected=done"); end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule